// File: doc/BRIEF.md
# Ring-Enabled Multiphase Clock Generator

This block produces a set of equally spaced, lower-rate square-wave phases (eight by default, sixteen by parameter) from a single fast clock, with no PLL or DLL involved. The fast clock runs at PHASES times the output rate. A circular one-hot register steps one position per fast cycle, and the bit it holds selects which phase changes on that cycle. With eight phases the outputs sit 45 degrees apart, from 0 to 315 degrees.

Each phase is kept as a toggle state bit. The state bit is set when the ring points at its own index and cleared when the ring points at the opposite index. Every phase then passes through one final register on the fast clock. Because all phases are launched from that same register bank, the routing skew between them stays small.

A `run` input starts and stops the phases at any time, with no lock or training sequence. While `run` is low the ring keeps its position and every output is driven low. On each rising edge of `run` the ring is reloaded with a single one in bit 0, so phase 0 is always the first to rise. A one-hot checker watches the ring, raises an error flag when the ring pattern is invalid, and reloads the ring.

Top module: `multiphase_ring_gen`

## Requirements
- R1: While `rstN` is low, every bit of `phaseOut` is 0 and `ringErr` is 0, whatever the level of `run`.
- R2: After reset, `phaseOut` stays all zero until the first rising clock edge that samples `run` high.
- R3: Call the first edge that samples `run` high after a low sample (or after reset) edge 0. Bit 0 of `phaseOut` rises after edge 2 and bit k rises after edge 2+k. Every phase rises in ascending index order.
- R4: Once a phase has started, it is high for PHASES/2 fast cycles and low for PHASES/2 fast cycles. Its period is PHASES fast cycles, which gives a 50% duty cycle.
- R5: Once both have started, phase k and phase k+PHASES/2 are complementary. At most two output bits change on any cycle while running.
- R6: From the first edge that samples `run` low, all `phaseOut` bits are 0 on the next cycle and stay 0 while `run` stays low. A `run` pulse one cycle long produces no output activity.
- R7: A restart after a stop repeats the R3 sequence exactly, whatever ring position the stop happened at.
- R8: The ring always holds exactly one set bit. If it ever holds any other pattern, `ringErr` is 1 on the following cycle and the ring is reloaded with bit 0 set. In normal operation `ringErr` stays 0.
- R9: With PHASES = 16 the same rules hold: sixteen phases spaced 22.5 degrees apart, each with a period of 16 fast cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, PHASES times the output rate |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High lets the phases run; low stops them and drives them low |
| phaseOut | output | PHASES | Registered phase outputs; bit k lags bit 0 by k fast cycles |
| ringErr | output | 1 | High for one cycle after an invalid ring pattern is seen |

## Verification
The main function is driven in five ways:
- A long run from a clean start. This separates the correct rise order, the duty cycle and the complementary pairs from off-by-one ring or output-stage errors.
- A stop in the middle of a period, followed by a restart. This shows whether the restart reloads the ring or resumes from the old position.
- A run pulse one cycle long. This shows whether a momentary start leaks any edge onto the outputs.
- A start with `run` already high as reset is released. This checks that the first edge after reset counts as a start.
- An eight-phase and a sixteen-phase instance driven side by side. This checks that the phase spacing follows the parameter rather than a fixed count.

// File: rtl/mphase_pkg.sv
package mphase_pkg;

  // Strobes from the sequencing control into the phase datapath
  typedef struct packed {
    logic load;   // reseed the ring with bit 0 and clear all phase states
    logic step;   // advance the ring and apply the set/clear enables
    logic clear;  // hold the ring, force phase states low
    logic outEn;  // let phase states reach the output register
  } ctlStrobes_t;

endpackage

// File: rtl/mphase_ctrl.sv
module mphase_ctrl
  import mphase_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        run,
  input  logic        ringBad,
  output ctlStrobes_t strb,
  output logic        ringErr
);

  logic runQ;
  logic runRise;

  assign runRise = run & ~runQ;

  always_comb begin
    strb.load  = runRise | ringBad;
    strb.step  = run & ~strb.load;
    strb.clear = ~run;
    strb.outEn = run;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      ringErr <= 1'b0;
    end else begin
      runQ    <= run;
      ringErr <= ringBad;
    end
  end

endmodule

// File: rtl/mphase_path.sv
module mphase_path
  import mphase_pkg::*;
#(
  parameter int PHASES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  output logic [PHASES-1:0] phaseOut,
  output logic [PHASES-1:0] ringState,
  output logic              ringBad
);

  localparam int HALF = PHASES / 2;
  localparam logic [PHASES-1:0] RING_SEED = {{(PHASES-1){1'b0}}, 1'b1};

  logic [PHASES-1:0] ring;
  logic [PHASES-1:0] state;
  logic [PHASES-1:0] stateNext;

  assign ringState = ring;
  assign ringBad   = ($countones(ring) != 1);

  // Per-phase toggle: set at own index, clear at opposite index
  for (genvar k = 0; k < PHASES; k++) begin : g_phase
    localparam int OPP = (k + HALF) % PHASES;
    assign stateNext[k] = (strb.clear || strb.load) ? 1'b0 :
                          (strb.step && ring[k])    ? 1'b1 :
                          (strb.step && ring[OPP])  ? 1'b0 :
                                                      state[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ring     <= RING_SEED;
      state    <= '0;
      phaseOut <= '0;
    end else begin
      if (strb.load)
        ring <= RING_SEED;
      else if (strb.step)
        ring <= {ring[PHASES-2:0], ring[PHASES-1]};
      state    <= stateNext;
      phaseOut <= strb.outEn ? state : '0;
    end
  end

endmodule

// File: rtl/multiphase_ring_gen.sv
module multiphase_ring_gen
  import mphase_pkg::*;
#(
  parameter int PHASES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  output logic [PHASES-1:0] phaseOut,
  output logic              ringErr
);

  ctlStrobes_t       strb;
  logic              ringBad;
  logic [PHASES-1:0] ringState;

  mphase_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .run     (run),
    .ringBad (ringBad),
    .strb    (strb),
    .ringErr (ringErr)
  );

  mphase_path #(.PHASES(PHASES)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .phaseOut  (phaseOut),
    .ringState (ringState),
    .ringBad   (ringBad)
  );

endmodule

// File: rtl/mphase_chk.sv
module mphase_chk #(
  parameter int PHASES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              run,
  input logic [PHASES-1:0] phaseOut,
  input logic [PHASES-1:0] ringState,
  input logic              ringErr
);

  localparam logic [PHASES-1:0] SEED = {{(PHASES-1){1'b0}}, 1'b1};

  logic              runPrev;
  logic              runPrev2;
  logic [PHASES-1:0] outPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runPrev  <= 1'b0;
      runPrev2 <= 1'b0;
      outPrev  <= '0;
    end else begin
      runPrev  <= run;
      runPrev2 <= runPrev;
      outPrev  <= phaseOut;
    end
  end

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runPrev |-> (phaseOut == '0));

  // R3
  reload_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !runPrev) |=> (ringState == SEED));

  // R8
  ring_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ringState) == 1);

  // R8
  no_ring_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ringErr);

  // R5
  step_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runPrev && runPrev2) |-> ($countones(phaseOut ^ outPrev) <= 2));

endmodule

bind multiphase_ring_gen mphase_chk #(.PHASES(PHASES)) u_mphase_chk (
  .clk       (clk),
  .rstN      (rstN),
  .run       (run),
  .phaseOut  (phaseOut),
  .ringState (ringState),
  .ringErr   (ringErr)
);

// File: tb/test_multiphase_ring_gen.sv
`timescale 1ns/1ps
module test_multiphase_ring_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic [7:0]  out8;
  logic [15:0] out16;
  logic        err8;
  logic        err16;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  multiphase_ring_gen #(.PHASES(8)) i_multiphase_ring_gen (
    .clk(clk), .rstN(rstN), .run(run), .phaseOut(out8), .ringErr(err8));

  multiphase_ring_gen #(.PHASES(16)) i_multiphase_ring_gen_w16 (
    .clk(clk), .rstN(rstN), .run(run), .phaseOut(out16), .ringErr(err16));

  // Expected outputs n edges after the starting edge (edge 0)
  function automatic logic [15:0] model(int n, int p);
    logic [15:0] v = '0;
    for (int k = 0; k < p; k++) begin
      int m = n - 2 - k;
      if (m >= 0 && (m % p) < (p / 2)) v[k] = 1'b1;
    end
    return v;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleWindow(int cycles, string tag);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); @(negedge clk);
      check(tag, {8'h00, out8}, 16'h0000);
      check({tag, " R9"}, out16, 16'h0000);
    end
  endtask

  // run must already be high, with the previous edge having sampled it low
  task automatic liveWindow(int cycles, string tagEarly, string tagLate);
    for (int n = 0; n < cycles; n++) begin
      @(posedge clk); @(negedge clk);
      check((n < 10) ? tagEarly : tagLate, {8'h00, out8}, model(n, 8));
      check("R9", out16, model(n, 16));
      check("R8", {15'b0, err8 | err16}, 16'h0000);
      if (n >= 10) check("R5", {12'h000, out8[3:0]}, {12'h000, ~out8[7:4]});
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", {8'h00, out8}, 16'h0000);
    check("R1", {15'b0, err8 | err16}, 16'h0000);
    rstN = 1'b1;
    idleWindow(10, "R2");
  endtask

  task automatic testStart();
    run = 1'b1;
    liveWindow(40, "R3", "R4");
  endtask

  task automatic testStop();
    run = 1'b0;
    idleWindow(6, "R6");
  endtask

  task automatic testRestart();
    run = 1'b1;
    liveWindow(13, "R7", "R7");
    run = 1'b0;
    idleWindow(3, "R6");
    run = 1'b1;
    liveWindow(30, "R7", "R7");
    run = 1'b0;
    idleWindow(3, "R6");
  endtask

  task automatic testPulse();
    run = 1'b1;
    @(posedge clk); @(negedge clk);
    run = 1'b0;
    check("R6", {8'h00, out8}, 16'h0000);
    idleWindow(6, "R6");
  endtask

  task automatic testResetRunHigh();
    rstN = 1'b0;
    run  = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {8'h00, out8}, 16'h0000);
    check("R1", out16, 16'h0000);
    rstN = 1'b1;
    liveWindow(24, "R2", "R4");
    run = 1'b0;
  endtask

  initial begin
    testReset();
    testStart();
    testStop();
    testRestart();
    testPulse();
    testResetRunHigh();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule